// File: doc/BRIEF.md
# Single-Instruction Repeat Loop Controller

This sequencer sits beside the fetch stage of a small 16-bit processor. It watches each fetched word for a repeat opcode, which comes in three forms. Two forms take the loop count from a data-memory word, selected either by a 7-bit direct offset or by indirect-address fields that are passed on undecoded. The third form carries an 8-bit count inside the opcode. Once the count is loaded, the controller keeps the fetch address where it is, so the instruction after the repeat is issued again and again. That instruction executes one more time than the loaded count.

From the repeat opcode to the last pass of the loop, interrupt requests are held back. The loop behaves as one uninterruptible multicycle operation because the count cannot be saved. A repeat opcode that shows up as the repeated instruction is not repeated: it runs once, closes the loop and loads nothing. The repeat opcode is one word long and changes no status bits. Auxiliary-register arithmetic and the execution of the repeated instruction belong to neighbouring blocks.

Top module: `rpt_loop_ctrl`

## Requirements
- R1: A valid word whose bits 15..8 are 8'h0B and whose bit 7 is 0 is the direct form. In that cycle `mem_rd_o`=1, `mem_ind_o`=0, `mem_dma_o` = word bits 6..0, `pc_adv_o`=1 and `exec_vld_o`=0.
- R2: A valid word whose bits 15..8 are 8'h0B and whose bit 7 is 1 is the indirect form. In that cycle `mem_rd_o`=1, `mem_ind_o`=1, `mem_aru_o` = bits 6..4, `mem_nbit_o` = bit 3, `mem_nar_o` = bits 2..0 and `pc_adv_o`=1.
- R3: A valid word whose bits 15..8 are 8'hBB is the immediate form. It advances the PC and issues no memory request. From the next cycle `rpt_cnt_o` holds bits 7..0, zero-extended.
- R4: After either memory form, the controller waits without executing and without advancing the PC until `mem_rsp_vld_i`=1. It then loads `mem_rsp_data_i` into `rpt_cnt_o` on that edge.
- R5: The instruction after the repeat is issued through `exec_vld_o` on (loaded count + 1) valid fetches. `pc_adv_o` stays 0 on all of them except the last, where it is 1.
- R6: Each loop execution with a nonzero count lowers `rpt_cnt_o` by one. A fetch with `instr_vld_i`=0 leaves it unchanged. The count is 0 after the loop ends.
- R7: `irq_o` follows `irq_i` only while `rpt_busy_o`=0 and no repeat opcode is being decoded. Otherwise it is 0.
- R8: A repeat opcode fetched inside a loop executes once with `pc_adv_o`=1. It ends the loop, clears the count and issues no memory request.
- R9: After reset `rpt_cnt_o`=0 and `rpt_busy_o`=0.
- R10: Outside a loop, a word that is not a repeat opcode passes through: `exec_vld_o` and `pc_adv_o` both equal `instr_vld_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_i | input | 16 | Fetched instruction word |
| instr_vld_i | input | 1 | Fetched word is valid this cycle |
| mem_rd_o | output | 1 | Read request for the count word |
| mem_ind_o | output | 1 | Request uses indirect addressing |
| mem_dma_o | output | 7 | Direct-form low address bits |
| mem_aru_o | output | 3 | Indirect-form register update code |
| mem_nbit_o | output | 1 | Indirect-form next-register enable |
| mem_nar_o | output | 3 | Indirect-form next register index |
| mem_rsp_vld_i | input | 1 | Count word is present |
| mem_rsp_data_i | input | 16 | Count word |
| irq_i | input | 1 | Interrupt request in |
| irq_o | output | 1 | Interrupt request after masking |
| exec_vld_o | output | 1 | Issue the current word to execution |
| pc_adv_o | output | 1 | Advance the program counter |
| rpt_busy_o | output | 1 | A repeat is being set up or run |
| rpt_cnt_o | output | 16 | Remaining repeat count |

## Verification
The hardest collision is a repeat opcode arriving as the repeated instruction. In that one cycle, loop termination and a fresh decode both want the counter. The bench fetches direct and immediate repeat words inside running loops. It expects exactly one execution, the PC to advance, no memory request and a count of zero afterwards. A second collision is the last pass of a loop coinciding with an interrupt request. The bench holds `irq_i` high across the whole loop and judges that it stays masked up to that final pass and is released only on the following idle cycle.

// File: rtl/rptl_pkg.sv
package rptl_pkg;
  localparam int INSTR_W = 16;
  localparam int IMM_W   = 8;
  localparam int DMA_W   = 7;
  localparam logic [7:0] OPC_MEM = 8'h0B;
  localparam logic [7:0] OPC_IMM = 8'hBB;

  typedef enum logic [1:0] {FORM_NONE, FORM_DIR, FORM_IND, FORM_IMM} rpt_form_e;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_LOOP} seq_st_e;

  // Sort a fetched word into one of the repeat forms.
  function automatic rpt_form_e classify(input logic [INSTR_W-1:0] w);
    if (w[15:8] == OPC_MEM) return w[7] ? FORM_IND : FORM_DIR;
    if (w[15:8] == OPC_IMM) return FORM_IMM;
    return FORM_NONE;
  endfunction

  // Widen the short count with zeros.
  function automatic logic [31:0] widen_imm(input logic [IMM_W-1:0] k);
    return {{(32-IMM_W){1'b0}}, k};
  endfunction
endpackage

// File: rtl/rptl_decode.sv
module rptl_decode
  import rptl_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output rpt_form_e          form_o,
  output logic [DMA_W-1:0]   dma_o,
  output logic [2:0]         aru_o,
  output logic               nbit_o,
  output logic [2:0]         nar_o,
  output logic [IMM_W-1:0]   k_o
);
  always_comb begin
    form_o = classify(instr_i);
    dma_o  = instr_i[DMA_W-1:0];
    aru_o  = instr_i[6:4];
    nbit_o = instr_i[3];
    nar_o  = instr_i[2:0];
    k_o    = instr_i[IMM_W-1:0];
  end
endmodule

// File: rtl/rptl_counter.sv
module rptl_counter
  import rptl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             ld_imm_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             ld_mem_i,
  input  logic [CNT_W-1:0] mem_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [31:0] imm_wide;
  logic [31:0] imm_hi_unused;

  assign imm_wide      = widen_imm(imm_i);
  assign imm_hi_unused = imm_wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_o <= '0;
    else if (clr_i)    cnt_o <= '0;
    else if (ld_imm_i) cnt_o <= imm_hi_unused[CNT_W-1:0];
    else if (ld_mem_i) cnt_o <= mem_i;
    else if (dec_i)    cnt_o <= cnt_o - CNT_W'(1);
  end

  assign zero_o = (cnt_o == '0);
endmodule

// File: rtl/rptl_fsm.sv
module rptl_fsm
  import rptl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      vld_i,
  input  rpt_form_e form_i,
  input  logic      rsp_vld_i,
  input  logic      cnt_zero_i,
  output logic      exec_o,
  output logic      pc_adv_o,
  output logic      mem_rd_o,
  output logic      ld_imm_o,
  output logic      ld_mem_o,
  output logic      dec_o,
  output logic      clr_o,
  output logic      busy_o,
  output logic      waiting_o,
  output logic      looping_o,
  output logic      rpt_seen_o
);
  seq_st_e st_q, st_d;
  logic    last_pass;

  assign rpt_seen_o = vld_i && (form_i != FORM_NONE);

  always_comb begin
    st_d      = st_q;
    exec_o    = 1'b0;
    pc_adv_o  = 1'b0;
    mem_rd_o  = 1'b0;
    ld_imm_o  = 1'b0;
    ld_mem_o  = 1'b0;
    dec_o     = 1'b0;
    clr_o     = 1'b0;
    last_pass = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        exec_o   = vld_i && !rpt_seen_o;
        pc_adv_o = vld_i;
        mem_rd_o = vld_i && (form_i == FORM_DIR || form_i == FORM_IND);
        ld_imm_o = vld_i && (form_i == FORM_IMM);
        if (ld_imm_o)      st_d = ST_LOOP;
        else if (mem_rd_o) st_d = ST_FETCH;
      end
      ST_FETCH: begin
        ld_mem_o = rsp_vld_i;
        if (rsp_vld_i) st_d = ST_LOOP;
      end
      ST_LOOP: begin
        exec_o    = vld_i;
        last_pass = vld_i && (cnt_zero_i || rpt_seen_o);
        pc_adv_o  = last_pass;
        dec_o     = vld_i && !last_pass;
        clr_o     = rpt_seen_o;
        if (last_pass) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign waiting_o = (st_q == ST_FETCH);
  assign looping_o = (st_q == ST_LOOP);
endmodule

// File: rtl/rpt_loop_ctrl.sv
module rpt_loop_ctrl
  import rptl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               instr_vld_i,
  output logic               mem_rd_o,
  output logic               mem_ind_o,
  output logic [DMA_W-1:0]   mem_dma_o,
  output logic [2:0]         mem_aru_o,
  output logic               mem_nbit_o,
  output logic [2:0]         mem_nar_o,
  input  logic               mem_rsp_vld_i,
  input  logic [CNT_W-1:0]   mem_rsp_data_i,
  input  logic               irq_i,
  output logic               irq_o,
  output logic               exec_vld_o,
  output logic               pc_adv_o,
  output logic               rpt_busy_o,
  output logic [CNT_W-1:0]   rpt_cnt_o
);
  rpt_form_e        form;
  logic [IMM_W-1:0] imm_k;
  logic             ld_imm, ld_mem, dec_en, clr_en, cnt_zero;
  logic             in_fetch, in_loop, rpt_seen;

  rptl_decode u_dec (
    .instr_i (instr_i),
    .form_o  (form),
    .dma_o   (mem_dma_o),
    .aru_o   (mem_aru_o),
    .nbit_o  (mem_nbit_o),
    .nar_o   (mem_nar_o),
    .k_o     (imm_k)
  );

  rptl_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .vld_i      (instr_vld_i),
    .form_i     (form),
    .rsp_vld_i  (mem_rsp_vld_i),
    .cnt_zero_i (cnt_zero),
    .exec_o     (exec_vld_o),
    .pc_adv_o   (pc_adv_o),
    .mem_rd_o   (mem_rd_o),
    .ld_imm_o   (ld_imm),
    .ld_mem_o   (ld_mem),
    .dec_o      (dec_en),
    .clr_o      (clr_en),
    .busy_o     (rpt_busy_o),
    .waiting_o  (in_fetch),
    .looping_o  (in_loop),
    .rpt_seen_o (rpt_seen)
  );

  rptl_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_en),
    .ld_imm_i (ld_imm),
    .imm_i    (imm_k),
    .ld_mem_i (ld_mem),
    .mem_i    (mem_rsp_data_i),
    .dec_i    (dec_en),
    .cnt_o    (rpt_cnt_o),
    .zero_o   (cnt_zero)
  );

  assign mem_ind_o = (form == FORM_IND);
  assign irq_o     = irq_i && !rpt_busy_o && !rpt_seen;
endmodule

// File: rtl/rptl_chk.sv
module rptl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_imm,
  input logic             ld_mem,
  input logic             in_fetch,
  input logic             in_loop,
  input logic             rpt_seen,
  input logic [7:0]       k_bits,
  input logic [CNT_W-1:0] rsp_data,
  input logic [CNT_W-1:0] cnt,
  input logic             vld,
  input logic             busy,
  input logic             irq_out,
  input logic             exec,
  input logic             pc_adv,
  input logic             mem_rd
);
  p_imm_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_imm |=> cnt == CNT_W'($past(k_bits)));

  p_mem_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mem |=> cnt == $past(rsp_data));

  p_wait_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_fetch |-> !exec && !pc_adv);

  p_hold_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_loop && cnt != '0 && !rpt_seen) |-> !pc_adv);

  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_loop && vld && cnt != '0 && !rpt_seen) |=> cnt == $past(cnt) - CNT_W'(1));

  p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq_out);

  p_nested_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_loop && rpt_seen) |-> pc_adv && !mem_rd);

  p_nested_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_loop && rpt_seen) |=> !busy && cnt == '0);
endmodule

bind rpt_loop_ctrl rptl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ld_imm   (ld_imm),
  .ld_mem   (ld_mem),
  .in_fetch (in_fetch),
  .in_loop  (in_loop),
  .rpt_seen (rpt_seen),
  .k_bits   (imm_k),
  .rsp_data (mem_rsp_data_i),
  .cnt      (rpt_cnt_o),
  .vld      (instr_vld_i),
  .busy     (rpt_busy_o),
  .irq_out  (irq_o),
  .exec     (exec_vld_o),
  .pc_adv   (pc_adv_o),
  .mem_rd   (mem_rd_o)
);

// File: tb/test_rpt_loop_ctrl.sv
`timescale 1ns/1ps
module test_rpt_loop_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic        ivld = 1'b0;
  logic        mem_rd, mem_ind, nbit, irq_out, exec, pc_adv, busy;
  logic [6:0]  dma;
  logic [2:0]  aru, nar;
  logic        rsp_vld = 1'b0;
  logic [15:0] rsp_data = '0;
  logic        irq = 1'b0;
  logic [15:0] cnt;

  always #4 clk = ~clk;

  rpt_loop_ctrl i_rpt_loop_ctrl (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .instr_vld_i(ivld),
    .mem_rd_o(mem_rd), .mem_ind_o(mem_ind), .mem_dma_o(dma),
    .mem_aru_o(aru), .mem_nbit_o(nbit), .mem_nar_o(nar),
    .mem_rsp_vld_i(rsp_vld), .mem_rsp_data_i(rsp_data),
    .irq_i(irq), .irq_o(irq_out), .exec_vld_o(exec), .pc_adv_o(pc_adv),
    .rpt_busy_o(busy), .rpt_cnt_o(cnt)
  );

  typedef struct {
    string       tag;
    logic        exec, pc, busy, irq, memrd;
    logic [15:0] cnt;
  } exp_t;

  exp_t sbq[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   m_st  = 0;
  logic [15:0] m_cnt = '0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected record per cycle.
  always @(negedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk(e.tag, "exec",   32'(exec),    32'(e.exec));
      chk(e.tag, "pc_adv", 32'(pc_adv),  32'(e.pc));
      chk(e.tag, "busy",   32'(busy),    32'(e.busy));
      chk(e.tag, "irq",    32'(irq_out), 32'(e.irq));
      chk(e.tag, "mem_rd", 32'(mem_rd),  32'(e.memrd));
      chk(e.tag, "count",  32'(cnt),     32'(e.cnt));
    end
  end

  // Driver: applies one cycle of stimulus and pushes the expectation.
  task automatic step(input string tag, input logic [15:0] w, input logic v,
                      input logic rv, input logic [15:0] rd, input logic iq);
    exp_t e;
    logic rep, memf;
    @(negedge clk);
    instr = w; ivld = v; rsp_vld = rv; rsp_data = rd; irq = iq;
    rep  = v && (w[15:8] == 8'h0B || w[15:8] == 8'hBB);
    memf = v && (w[15:8] == 8'h0B);
    e.tag = tag; e.cnt = m_cnt;
    if (m_st == 0) begin
      e.exec = v && !rep; e.pc = v; e.busy = 0; e.irq = iq && !rep; e.memrd = memf;
      if (rep && w[15:8] == 8'hBB) begin m_st = 2; m_cnt = {8'h00, w[7:0]}; end
      else if (memf) m_st = 1;
    end else if (m_st == 1) begin
      e.exec = 0; e.pc = 0; e.busy = 1; e.irq = 0; e.memrd = 0;
      if (rv) begin m_st = 2; m_cnt = rd; end
    end else begin
      e.exec = v; e.pc = v && (rep || m_cnt == 0); e.busy = 1; e.irq = 0; e.memrd = 0;
      if (v) begin
        if (rep || m_cnt == 0) begin m_st = 0; m_cnt = '0; end
        else m_cnt = m_cnt - 16'd1;
      end
    end
    sbq.push_back(e);
    if (memf && e.memrd) begin
      #1;
      chk(tag, "mem_ind", 32'(mem_ind), 32'(w[7]));
      if (!w[7]) chk("R1", "dma", 32'(dma), 32'(w[6:0]));
      else begin
        chk("R2", "aru",  32'(aru),  32'(w[6:4]));
        chk("R2", "nbit", 32'(nbit), 32'(w[3]));
        chk("R2", "nar",  32'(nar),  32'(w[2:0]));
      end
    end
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    step("R9", 16'h0000, 0, 0, 0, 0);
    // R10: plain words pass, interrupt passes
    step("R10", 16'h1234, 1, 0, 0, 1);
    step("R10", 16'h7F00, 1, 0, 0, 0);
    // R3/R5/R7: immediate count 2, interrupt held high throughout
    step("R3", 16'hBB02, 1, 0, 0, 1);
    step("R5", 16'h5555, 1, 0, 0, 1);
    step("R6", 16'h5555, 0, 0, 0, 1);
    step("R5", 16'h5555, 1, 0, 0, 1);
    step("R7", 16'h5555, 1, 0, 0, 1);
    step("R7", 16'h6666, 1, 0, 0, 1);
    // R5: count 0 gives one execution
    step("R3", 16'hBB00, 1, 0, 0, 0);
    step("R5", 16'h4321, 1, 0, 0, 0);
    // R1/R4: direct form, slow response, count 1
    step("R1", 16'h0B05, 1, 0, 0, 0);
    step("R4", 16'h2222, 1, 0, 16'h0009, 1);
    step("R4", 16'h2222, 1, 0, 16'h0009, 0);
    step("R4", 16'h2222, 1, 1, 16'h0001, 0);
    step("R5", 16'h2222, 1, 0, 0, 0);
    step("R5", 16'h2222, 1, 0, 0, 0);
    // R2/R4/R6: indirect form, count 3 with fetch gaps
    step("R2", 16'h0BB9, 1, 0, 0, 0);
    step("R4", 16'h3333, 0, 1, 16'h0003, 0);
    step("R6", 16'h3333, 1, 0, 0, 0);
    step("R6", 16'h3333, 0, 0, 0, 0);
    step("R6", 16'h3333, 1, 0, 0, 0);
    step("R6", 16'h3333, 1, 0, 0, 1);
    step("R5", 16'h3333, 1, 0, 0, 1);
    step("R10", 16'h0101, 1, 0, 0, 1);
    // R8: repeat opcodes inside a loop
    step("R3", 16'hBB05, 1, 0, 0, 0);
    step("R6", 16'h7777, 1, 0, 0, 0);
    step("R8", 16'h0B10, 1, 0, 0, 1);
    step("R8", 16'h0000, 0, 0, 0, 0);
    // R3: full 8-bit count is zero-extended, loop closed by nested immediate
    step("R3", 16'hBBFF, 1, 0, 0, 0);
    step("R3", 16'h1111, 0, 0, 0, 0);
    step("R6", 16'h1111, 1, 0, 0, 0);
    step("R8", 16'hBB03, 1, 0, 0, 0);
    step("R8", 16'h1111, 1, 0, 0, 1);
    step("R9", 16'h0000, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    #4;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule